// File: doc/BRIEF.md
# SPI Serial Byte Memory Slave with Quarter-Granular Write Protection

This block is an SPI slave that fronts a 1024-byte memory. An SPI master reads bytes from any address and the address advances by itself. It writes up to one 32-byte page per select, and it reads or changes an 8-bit status register. Every change of memory or protection needs a prior write-enable command. Each change is followed by a self-timed busy period, whose length is a count of system clocks.

All SPI pins are sampled by the system clock through a short synchronizer, and SCK edges are detected from the sampled values. SCK must therefore run well below the system clock. A two-bit protection field makes the top quarter, the top half or all of the array read-only. A hardware write-protect pin locks that field. A hold pin pauses a transfer without ending it.

Top module: `spimem_top`

## Requirements
- R1: SPI modes 0 and 3 both work. SI is taken on the rising SCK edge and SO moves on the falling SCK edge, MSB first.
- R2: The status byte reads as bit 0 busy, bit 1 write-enable, bits 3:2 protection field, and 0 in bits 7:4. It reads 0x00 after reset. Opcode 0x05 returns it, repeated for as long as SCK runs.
- R3: Opcode 0x06 sets the write-enable bit and opcode 0x04 clears it. Both take effect only when the block is not busy.
- R4: Opcode 0x03 is followed by a 16-bit address, high byte first, of which only bits 9:0 count. It returns bytes from that address and advances by one per byte, going from 0x3FF to 0x000.
- R5: With the write-enable bit set, opcode 0x02 with a 16-bit address stores the following bytes when CS rises on a byte boundary. The low five address bits advance and wrap inside the same 32-byte page.
- R6: Opcode 0x02 or 0x01 with the write-enable bit clear changes nothing and starts no busy period.
- R7: Protection field 00 protects nothing, 01 protects 0x300..0x3FF, 10 protects 0x200..0x3FF and 11 protects everything. Bytes aimed at a protected address are dropped without notice.
- R8: Opcode 0x01 with one data byte sets the protection field from data bits 3:2 when the write-enable bit is set. While WP is low the status write is ignored and the write-enable bit stays set.
- R9: The write-enable bit clears when a memory or status write is committed. It also clears when CS rises at a non-byte boundary after opcode 0x02 or 0x01 was accepted.
- R10: A commit sets the busy bit for WRITE_CYCLES system clocks. While it is set only opcode 0x05 is honoured, and any other read shifts out 0x00.
- R11: While HOLD is low, SCK and SI are ignored and so_en_o is low. After HOLD is released the transfer continues from the bit where it stopped.
- R12: so_en_o is low while CS is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | SPI serial clock |
| si_i | input | 1 | SPI serial data into the block |
| cs_ni | input | 1 | Chip select, active low |
| hold_ni | input | 1 | Transfer pause, active low |
| wp_ni | input | 1 | Status write lock, active low |
| so_o | output | 1 | SPI serial data out of the block |
| so_en_o | output | 1 | Output enable for so_o; low means high impedance |

## Verification
The assertions assume that CS, HOLD and WP stay at one level for longer than the synchronizer depth before their effect is checked. They also assume that HOLD changes only while SCK is low. The bench holds every pin for eight system clocks per half SCK period and moves HOLD only with SCK low. After every commit it polls the busy bit until it clears, except where a test probes the busy window on purpose.

// File: rtl/spimem_pkg.sv
package spimem_pkg;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  typedef enum logic [2:0] {
    PH_OPC, PH_ADDR, PH_WDATA, PH_RDATA, PH_STAT, PH_SDATA, PH_IDLE
  } phase_e;

  // quarter = two top address bits, prot = status protection field
  function automatic logic quarter_locked(input logic [1:0] quarter, input logic [1:0] prot);
    case (prot)
      2'b00:   return 1'b0;
      2'b01:   return quarter == 2'b11;
      2'b10:   return quarter[1];
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/spimem_frontend.sv
module spimem_frontend #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic si_i,
  input  logic cs_ni,
  input  logic hold_ni,
  input  logic wp_ni,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic si_o,
  output logic sel_o,
  output logic cs_rise_o,
  output logic held_o,
  output logic wp_o
);
  localparam logic [4:0] RST_V = 5'b00111;  // {sck, si, cs_n, hold_n, wp_n}

  logic [4:0] stg_q [SYNC_STAGES];
  logic [4:0] s;
  logic       sck_prev_q, cs_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SYNC_STAGES; i++) stg_q[i] <= RST_V;
      sck_prev_q <= 1'b0;
      cs_prev_q  <= 1'b1;
    end else begin
      stg_q[0] <= {sck_i, si_i, cs_ni, hold_ni, wp_ni};
      for (int i = 1; i < SYNC_STAGES; i++) stg_q[i] <= stg_q[i-1];
      sck_prev_q <= s[4];
      cs_prev_q  <= s[2];
    end
  end

  assign s          = stg_q[SYNC_STAGES-1];
  assign si_o       = s[3];
  assign sel_o      = !s[2];
  assign held_o     = !s[1];
  assign wp_o       = !s[0];
  assign cs_rise_o  = s[2] && !cs_prev_q;
  assign sck_rise_o = s[4] && !sck_prev_q && sel_o && !held_o;
  assign sck_fall_o = !s[4] && sck_prev_q && sel_o && !held_o;
endmodule

// File: rtl/spimem_ctrl.sv
module spimem_ctrl
  import spimem_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sck_rise_i,
  input  logic                     sck_fall_i,
  input  logic                     si_i,
  input  logic                     sel_i,
  input  logic                     cs_rise_i,
  input  logic                     wp_i,
  input  logic                     busy_i,
  input  logic [1:0]               prot_i,
  input  logic [7:0]               rd_data_i,
  output logic [ADDR_W-1:0]        rd_addr_o,
  output logic                     so_o,
  output logic                     wel_o,
  output logic                     buf_clr_o,
  output logic                     buf_we_o,
  output logic [PAGE_W-1:0]        buf_idx_o,
  output logic [7:0]               buf_data_o,
  output logic                     commit_arr_o,
  output logic [ADDR_W-PAGE_W-1:0] commit_page_o,
  output logic                     commit_st_o,
  output logic [1:0]               st_data_o
);
  localparam int HI_W = ADDR_W - 8;

  phase_e              phase_q;
  logic [2:0]          bit_cnt_q;
  logic [7:0]          shreg_q, tx_q;
  logic [HI_W-1:0]     addr_hi_q;
  logic [ADDR_W-1:0]   addr_q, page_next;
  logic                hi_done_q, got_q, wel_q, so_q, is_read_q, wr_txn_q;
  logic [1:0]          st_q;
  logic [7:0]          rx_byte, out_byte, status;
  logic                byte_done, boundary, abort;

  assign rx_byte   = {shreg_q[6:0], si_i};
  assign byte_done = sck_rise_i && (bit_cnt_q == 3'd7);
  assign boundary  = (bit_cnt_q == 3'd0);
  assign page_next = {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + PAGE_W'(1)};
  assign status    = {4'b0000, prot_i, wel_q, busy_i};
  assign out_byte  = (phase_q == PH_STAT)  ? status :
                     (phase_q == PH_RDATA) ? rd_data_i : 8'h00;

  assign buf_clr_o     = byte_done && (phase_q == PH_OPC) && (rx_byte == OP_WRITE);
  assign buf_we_o      = byte_done && (phase_q == PH_WDATA);
  assign buf_idx_o     = addr_q[PAGE_W-1:0];
  assign buf_data_o    = rx_byte;
  assign commit_arr_o  = cs_rise_i && (phase_q == PH_WDATA) && boundary && got_q;
  assign commit_st_o   = cs_rise_i && (phase_q == PH_SDATA) && boundary && got_q && !wp_i;
  assign abort         = cs_rise_i && wr_txn_q && !boundary;
  assign commit_page_o = addr_q[ADDR_W-1:PAGE_W];
  assign st_data_o     = st_q;
  assign rd_addr_o     = addr_q;
  assign wel_o         = wel_q;
  assign so_o          = so_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_OPC;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      tx_q      <= '0;
      addr_hi_q <= '0;
      addr_q    <= '0;
      hi_done_q <= 1'b0;
      got_q     <= 1'b0;
      wel_q     <= 1'b0;
      so_q      <= 1'b0;
      is_read_q <= 1'b0;
      wr_txn_q  <= 1'b0;
      st_q      <= '0;
    end else begin
      if (commit_arr_o || commit_st_o || abort) wel_q <= 1'b0;
      if (!sel_i) begin
        phase_q   <= PH_OPC;
        bit_cnt_q <= '0;
        hi_done_q <= 1'b0;
        got_q     <= 1'b0;
        wr_txn_q  <= 1'b0;
      end else begin
        if (sck_rise_i) begin
          shreg_q   <= rx_byte;
          bit_cnt_q <= bit_cnt_q + 3'd1;
        end
        if (byte_done) begin
          case (phase_q)
            PH_OPC: begin
              case (rx_byte)
                OP_WREN: begin
                  if (!busy_i) wel_q <= 1'b1;
                  phase_q <= PH_IDLE;
                end
                OP_WRDI: begin
                  if (!busy_i) wel_q <= 1'b0;
                  phase_q <= PH_IDLE;
                end
                OP_RDSR: phase_q <= PH_STAT;
                OP_READ: begin
                  phase_q   <= busy_i ? PH_IDLE : PH_ADDR;
                  is_read_q <= 1'b1;
                end
                OP_WRITE: begin
                  if (!busy_i && wel_q) begin
                    phase_q   <= PH_ADDR;
                    is_read_q <= 1'b0;
                    wr_txn_q  <= 1'b1;
                  end else phase_q <= PH_IDLE;
                end
                OP_WRSR: begin
                  if (!busy_i && wel_q) begin
                    phase_q  <= PH_SDATA;
                    wr_txn_q <= 1'b1;
                  end else phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
              endcase
            end
            PH_ADDR: begin
              if (!hi_done_q) begin
                addr_hi_q <= rx_byte[HI_W-1:0];
                hi_done_q <= 1'b1;
              end else begin
                addr_q  <= {addr_hi_q, rx_byte};
                phase_q <= is_read_q ? PH_RDATA : PH_WDATA;
              end
            end
            PH_WDATA: begin
              addr_q <= page_next;
              got_q  <= 1'b1;
            end
            PH_RDATA: addr_q <= addr_q + ADDR_W'(1);
            PH_SDATA: begin
              if (!got_q) begin
                st_q  <= rx_byte[3:2];
                got_q <= 1'b1;
              end
            end
            default: ;
          endcase
        end
        // new byte loads on the first falling edge of each byte slot
        if (sck_fall_i) begin
          if (boundary) begin
            so_q <= out_byte[7];
            tx_q <= {out_byte[6:0], 1'b0};
          end else begin
            so_q <= tx_q[7];
            tx_q <= {tx_q[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/spimem_store.sv
module spimem_store
  import spimem_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int PAGE_W       = 5,
  parameter int WRITE_CYCLES = 400
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     buf_clr_i,
  input  logic                     buf_we_i,
  input  logic [PAGE_W-1:0]        buf_idx_i,
  input  logic [7:0]               buf_data_i,
  input  logic                     commit_arr_i,
  input  logic [ADDR_W-PAGE_W-1:0] commit_page_i,
  input  logic                     commit_st_i,
  input  logic [1:0]               st_data_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [7:0]               rd_data_o,
  output logic                     busy_o,
  output logic [1:0]               prot_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  // page drain runs inside the busy window, so it must be longer than a page
  localparam int BUSY  = (WRITE_CYCLES > PAGE) ? WRITE_CYCLES : PAGE + 1;
  localparam int CNT_W = $clog2(BUSY + 1);

  logic [7:0]               mem_q [DEPTH];
  logic [7:0]               buf_q [PAGE];
  logic [PAGE-1:0]          vld_q;
  logic [CNT_W-1:0]         cnt_q;
  logic                     drain_q;
  logic [PAGE_W-1:0]        idx_q;
  logic [ADDR_W-PAGE_W-1:0] page_q;
  logic [1:0]               prot_q;
  logic [ADDR_W-1:0]        wr_addr;
  logic                     mem_we;

  assign wr_addr   = {page_q, idx_q};
  assign mem_we    = drain_q && vld_q[idx_q] && !quarter_locked(wr_addr[ADDR_W-1 -: 2], prot_q);
  assign rd_data_o = mem_q[rd_addr_i];
  assign busy_o    = (cnt_q != '0);
  assign prot_o    = prot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= '0;
      cnt_q   <= '0;
      drain_q <= 1'b0;
      idx_q   <= '0;
      page_q  <= '0;
      prot_q  <= '0;
    end else begin
      if (buf_clr_i) vld_q <= '0;
      else if (buf_we_i) vld_q[buf_idx_i] <= 1'b1;
      if (busy_o) cnt_q <= cnt_q - CNT_W'(1);
      if (drain_q) begin
        idx_q <= idx_q + PAGE_W'(1);
        if (idx_q == PAGE_W'(PAGE - 1)) drain_q <= 1'b0;
      end
      if (commit_arr_i) begin
        cnt_q   <= CNT_W'(BUSY);
        drain_q <= 1'b1;
        idx_q   <= '0;
        page_q  <= commit_page_i;
      end
      if (commit_st_i) begin
        cnt_q  <= CNT_W'(BUSY);
        prot_q <= st_data_i;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (mem_we) mem_q[wr_addr] <= buf_q[idx_q];
    if (buf_we_i) buf_q[buf_idx_i] <= buf_data_i;
  end
endmodule

// File: rtl/spimem_top.sv
module spimem_top #(
  parameter int ADDR_W       = 10,
  parameter int PAGE_W       = 5,
  parameter int SYNC_STAGES  = 2,
  parameter int WRITE_CYCLES = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic si_i,
  input  logic cs_ni,
  input  logic hold_ni,
  input  logic wp_ni,
  output logic so_o,
  output logic so_en_o
);
  logic                     sck_rise, sck_fall, si_s, sel, cs_rise, held, wp;
  logic                     busy, wel, buf_clr, buf_we, commit_arr, commit_st;
  logic [1:0]               prot, st_data;
  logic [PAGE_W-1:0]        buf_idx;
  logic [7:0]               buf_data, rd_data;
  logic [ADDR_W-1:0]        rd_addr;
  logic [ADDR_W-PAGE_W-1:0] commit_page;

  spimem_frontend #(.SYNC_STAGES(SYNC_STAGES)) i_frontend (
    .clk_i, .rst_ni, .sck_i, .si_i, .cs_ni, .hold_ni, .wp_ni,
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall), .si_o(si_s), .sel_o(sel),
    .cs_rise_o(cs_rise), .held_o(held), .wp_o(wp)
  );

  spimem_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_ctrl (
    .clk_i, .rst_ni, .sck_rise_i(sck_rise), .sck_fall_i(sck_fall), .si_i(si_s),
    .sel_i(sel), .cs_rise_i(cs_rise), .wp_i(wp), .busy_i(busy), .prot_i(prot),
    .rd_data_i(rd_data), .rd_addr_o(rd_addr), .so_o, .wel_o(wel),
    .buf_clr_o(buf_clr), .buf_we_o(buf_we), .buf_idx_o(buf_idx), .buf_data_o(buf_data),
    .commit_arr_o(commit_arr), .commit_page_o(commit_page), .commit_st_o(commit_st),
    .st_data_o(st_data)
  );

  spimem_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WRITE_CYCLES(WRITE_CYCLES)) i_store (
    .clk_i, .rst_ni, .buf_clr_i(buf_clr), .buf_we_i(buf_we), .buf_idx_i(buf_idx),
    .buf_data_i(buf_data), .commit_arr_i(commit_arr), .commit_page_i(commit_page),
    .commit_st_i(commit_st), .st_data_i(st_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .busy_o(busy), .prot_o(prot)
  );

  assign so_en_o = sel && !held;
endmodule

// File: rtl/spimem_chk.sv
module spimem_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic       hold_ni,
  input logic       wp_ni,
  input logic       so_en_o,
  input logic       wel,
  input logic       wip,
  input logic [1:0] prot
);
  localparam logic [3:0] LIM = 4'(SYNC_STAGES);

  logic [3:0] cs_hi_q, hold_lo_q, wp_lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_hi_q   <= '0;
      hold_lo_q <= '0;
      wp_lo_q   <= '0;
    end else begin
      cs_hi_q   <= !cs_ni   ? '0 : (cs_hi_q   == 4'hF ? cs_hi_q   : cs_hi_q   + 4'd1);
      hold_lo_q <= hold_ni  ? '0 : (hold_lo_q == 4'hF ? hold_lo_q : hold_lo_q + 4'd1);
      wp_lo_q   <= wp_ni    ? '0 : (wp_lo_q   == 4'hF ? wp_lo_q   : wp_lo_q   + 4'd1);
    end
  end

  a_r12_deselect_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && cs_hi_q >= LIM) |-> !so_en_o);
  a_r11_hold_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_ni && hold_lo_q >= LIM) |-> !so_en_o);
  a_r8_wp_freezes_prot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wp_ni && wp_lo_q >= LIM) |=> $stable(prot));
  a_r9_wel_clear_at_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip) |-> !wel);
  a_r6_commit_needs_wel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip) |-> $past(wel));
  a_r10_no_enable_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wip |=> !$rose(wel));
  a_r7_prot_moves_with_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(prot) |-> $rose(wip));
endmodule

bind spimem_top spimem_chk #(.SYNC_STAGES(SYNC_STAGES)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .hold_ni(hold_ni), .wp_ni(wp_ni),
  .so_en_o(so_en_o), .wel(wel), .wip(busy), .prot(prot)
);

// File: tb/test_spimem_top.sv
module test_spimem_top;
  localparam int H = 8;  // system clocks per half SCK period

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, si = 1'b0, cs_n = 1'b1, hold_n = 1'b1, wp_n = 1'b1;
  logic so, so_en;
  int   checks = 0, errors = 0;
  bit   mode3 = 1'b0, done = 1'b0;

  always #10 clk = ~clk;

  spimem_top i_spimem_top (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .si_i(si), .cs_ni(cs_n),
    .hold_ni(hold_n), .wp_ni(wp_n), .so_o(so), .so_en_o(so_en)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic b, output logic r);
    sck = 1'b0; si = b; tick(H);
    r = so;
    sck = 1'b1; tick(H);
  endtask

  task automatic sbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      logic r;
      sbit(tx[i], r);
      rx[i] = r;
    end
  endtask

  task automatic spi_open();
    sck = mode3; tick(H);
    cs_n = 1'b0; tick(H);
  endtask

  task automatic spi_close();
    if (!mode3) begin sck = 1'b0; tick(H); end
    cs_n = 1'b1; tick(2 * H);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] d;
    spi_open(); sbyte(op, d); spi_close();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    spi_open(); sbyte(8'h05, d); sbyte(8'h00, s); spi_close();
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 40; i++) begin
      rdsr(s);
      if (!s[0]) break;
    end
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    spi_open(); sbyte(8'h01, d); sbyte(v, d); spi_close();
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] data, input int n, input bit en);
    logic [7:0] d;
    if (en) cmd(8'h06);
    spi_open();
    sbyte(8'h02, d); sbyte(a[15:8], d); sbyte(a[7:0], d);
    for (int i = 0; i < n; i++) sbyte(data[31-8*i -: 8], d);
    spi_close();
  endtask

  task automatic rd(input logic [15:0] a, input int n, output logic [31:0] q);
    logic [7:0] d;
    q = '0;
    spi_open();
    sbyte(8'h03, d); sbyte(a[15:8], d); sbyte(a[7:0], d);
    for (int i = 0; i < n; i++) begin sbyte(8'h00, d); q[31-8*i -: 8] = d; end
    spi_close();
  endtask

  function automatic bit locked(input int q, input int p);
    return (p == 3) || (p == 2 && q >= 2) || (p == 1 && q == 3);
  endfunction

  task automatic t_reset();
    logic [7:0] s;
    check("R12 so_en after reset", {7'b0, so_en}, 8'h00);
    rdsr(s);
    check("R2 status after reset", s, 8'h00);
    check("R12 so_en with CS high", {7'b0, so_en}, 8'h00);
  endtask

  task automatic t_enable();
    logic [7:0] s;
    cmd(8'h06); rdsr(s); check("R3 WREN sets bit 1", s, 8'h02);
    cmd(8'h04); rdsr(s); check("R3 WRDI clears bit 1", s, 8'h00);
  endtask

  task automatic t_write_read();
    logic [7:0] s; logic [31:0] q;
    wr(16'h0010, 32'hA0A1A2A3, 4, 1);
    rdsr(s); check("R10 busy after commit, R9 WEL cleared", s, 8'h01);
    wait_idle();
    rd(16'h0010, 4, q);
    check("R4 read byte0", q[31:24], 8'hA0); check("R4 read byte1", q[23:16], 8'hA1);
    check("R4 read byte2", q[15:8], 8'hA2);  check("R5 page write byte3", q[7:0], 8'hA3);
    rd(16'hFC10, 1, q); check("R4 upper address bits ignored", q[31:24], 8'hA0);
  endtask

  task automatic t_page_wrap();
    logic [31:0] q;
    wr(16'h005E, 32'h01020304, 4, 1); wait_idle();
    rd(16'h005E, 2, q);
    check("R5 byte at 0x5E", q[31:24], 8'h01); check("R5 byte at 0x5F", q[23:16], 8'h02);
    rd(16'h0040, 2, q);
    check("R5 wrap to 0x40", q[31:24], 8'h03); check("R5 wrap to 0x41", q[23:16], 8'h04);
  endtask

  task automatic t_read_wrap();
    logic [31:0] q;
    wr(16'h03FF, 32'h77000000, 1, 1); wait_idle();
    wr(16'h0000, 32'h66000000, 1, 1); wait_idle();
    rd(16'h03FF, 2, q);
    check("R4 byte at 0x3FF", q[31:24], 8'h77); check("R4 wrap to 0x000", q[23:16], 8'h66);
  endtask

  task automatic t_no_enable();
    logic [7:0] s; logic [31:0] q;
    wr(16'h0010, 32'h55000000, 1, 0);
    rdsr(s); check("R6 no busy without WEL", s, 8'h00);
    rd(16'h0010, 1, q); check("R6 memory unchanged", q[31:24], 8'hA0);
  endtask

  task automatic t_protect();
    logic [7:0] s; logic [31:0] q; logic [7:0] cur [4];
    for (int k = 0; k < 4; k++) begin
      wr(16'(k * 256), 32'h5A000000, 1, 1); wait_idle(); cur[k] = 8'h5A;
    end
    for (int p = 1; p <= 3; p++) begin
      cmd(8'h06); wrsr(8'(p << 2)); wait_idle();
      rdsr(s); check("R8 protection field set", s, 8'(p << 2));
      for (int k = 0; k < 4; k++) begin
        logic [7:0] v;
        v = 8'(p * 16 + k);
        wr(16'(k * 256), {v, 24'h0}, 1, 1); wait_idle();
        if (!locked(k, p)) cur[k] = v;
        rd(16'(k * 256), 1, q);
        check($sformatf("R7 prot %0d quarter %0d", p, k), q[31:24], cur[k]);
      end
    end
    cmd(8'h06); wrsr(8'h00); wait_idle();
    rdsr(s); check("R8 protection cleared", s, 8'h00);
  endtask

  task automatic t_wp();
    logic [7:0] s;
    wp_n = 1'b0; tick(H);
    cmd(8'h06); wrsr(8'h0C); tick(H);
    rdsr(s); check("R8 WP blocks status write", s, 8'h02);
    wp_n = 1'b1; tick(H);
    cmd(8'h04);
  endtask

  task automatic t_abort();
    logic [7:0] s, d; logic [31:0] q;
    cmd(8'h06);
    spi_open();
    sbyte(8'h02, d); sbyte(8'h00, d); sbyte(8'h10, d); sbyte(8'h5C, d);
    for (int i = 0; i < 3; i++) begin logic r; sbit(1'b1, r); end
    spi_close();
    rdsr(s); check("R9 abort clears WEL, no busy", s, 8'h00);
    rd(16'h0010, 1, q); check("R9 aborted write not stored", q[31:24], 8'hA0);
  endtask

  task automatic t_busy();
    logic [7:0] s; logic [31:0] q;
    wr(16'h0070, 32'h33000000, 1, 1);
    cmd(8'h06);
    rd(16'h0010, 1, q); check("R10 read ignored while busy", q[31:24], 8'h00);
    wait_idle();
    rdsr(s); check("R10 WREN ignored while busy", s, 8'h00);
    rd(16'h0070, 1, q); check("R10 write landed after busy", q[31:24], 8'h33);
  endtask

  task automatic t_hold();
    logic [7:0] d, b0, b1;
    spi_open();
    sbyte(8'h03, d); sbyte(8'h00, d); sbyte(8'h10, d);
    for (int i = 7; i >= 4; i--) begin logic r; sbit(1'b0, r); b0[i] = r; end
    sck = 1'b0; tick(H);
    check("R11 so_en before hold", {7'b0, so_en}, 8'h01);
    hold_n = 1'b0; tick(H);
    check("R11 so_en low in hold", {7'b0, so_en}, 8'h00);
    for (int i = 0; i < 3; i++) begin
      sck = 1'b1; si = 1'b1; tick(H); sck = 1'b0; si = 1'b0; tick(H);
    end
    hold_n = 1'b1; tick(H);
    for (int i = 3; i >= 0; i--) begin logic r; sbit(1'b0, r); b0[i] = r; end
    sbyte(8'h00, b1);
    spi_close();
    check("R11 byte across hold", b0, 8'hA0);
    check("R11 next byte after hold", b1, 8'hA1);
  endtask

  task automatic t_mode3();
    logic [7:0] s; logic [31:0] q;
    mode3 = 1'b1;
    cmd(8'h06); rdsr(s); check("R1 mode 3 status", s, 8'h02);
    rd(16'h0010, 2, q);
    check("R1 mode 3 read byte0", q[31:24], 8'hA0); check("R1 mode 3 read byte1", q[23:16], 8'hA1);
    cmd(8'h04); rdsr(s); check("R1 mode 3 WRDI", s, 8'h00);
    mode3 = 1'b0;
  endtask

  initial begin
    tick(5); rst_n = 1'b1; tick(5);
    t_reset();
    t_enable();
    t_write_read();
    t_page_wrap();
    t_read_wrap();
    t_no_enable();
    t_protect();
    t_wp();
    t_abort();
    t_busy();
    t_hold();
    t_mode3();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule